// File: doc/BRIEF.md
# Swept-Frequency Word Generator with Phase Accumulator

This block produces the tuning word that sets the output frequency of a synthesizer, and it also accumulates that word into the phase that a later sine lookup would consume. A 3-bit mode input chooses the behaviour. Single tone outputs word A. Plain FSK picks word A or word B from a level input. Ramped FSK walks between word A (the low end) and word B (the high end) in paced steps. Chirp walks from word A with a signed step and no upper bound.

In the ramped modes a rate timer gives one step pulse every N+1 clocks, where N is the rate input. Each pulse adds or subtracts the step word. A pin-driven ramp stops at its destination and reverses at once if the pin flips part-way. A triangle enable makes the ramp bounce between the two ends on its own. A hold input freezes the ramp. Two clear controls are provided. One returns the word to its origin at an update strobe while the ramp carries on. The other forces both the frequency and the phase to zero for as long as it is held.

Top module: `fsk_chirp_engine`

## Requirements
- R1: With mode 000, or any mode whose top bit is 1, freq_o equals word_a_i one clock after the inputs are sampled.
- R2: With mode 001, freq_o equals word_b_i one clock after fsk_i is sampled high, and word_a_i one clock after it is sampled low.
- R3: In mode 010 the word holds still until fsk_i changes level. The clock that samples the change is the restart clock. Steps then land at restart + k·(N+1) clocks, where N = rate_i ≥ 1 and k ≥ 1. Each step moves the word by step_i, up toward word_b_i when fsk_i is high and down toward word_a_i when it is low.
- R4: A step that would reach or pass the destination leaves the word exactly at the destination. The word then stays there until fsk_i changes again.
- R5: If fsk_i changes level before the destination is reached, the ramp turns around at once with the same rate and step. The word does not move in the restart clock, and steps resume every N+1 clocks after it.
- R6: In mode 010 with tri_en_i high, fsk_i is ignored and the word sweeps without stopping between word_a_i and word_b_i, turning at each end. At the rising edge of tri_en_i the word loads word_a_i and heads up if fsk_i is low, or loads word_b_i and heads down if fsk_i is high.
- R7: On entry to mode 011 the word loads word_a_i, and that clock is a restart. Each step then adds step_i as a two's-complement value, modulo 2^FW, with no bound at word_b_i.
- R8: While hold_i is high the word and the rate timer are frozen. Held clocks do not count toward the N+1 spacing.
- R9: In the swept modes, update_i and clr_ramp_i high together return the word to its origin: word_a_i in chirp or on a rising ramp, word_b_i on a falling ramp. That clock is a restart. With clr_ramp_i held high, each update_i pulse repeats the clear. update_i alone has no effect.
- R10: While clr_all_i is high, freq_o and phase_o are zero from the next clock on. After release the word resumes from its origin, and the timer counts from the last cleared clock.
- R11: Reset clears freq_o and phase_o. Each clock the phase accumulator adds freq_o, wrapping at 2^FW, and phase_o is its top PW bits, so a frequency change keeps the phase continuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | 000 tone, 001 FSK, 010 ramped FSK, 011 chirp, 1xx tone |
| fsk_i | input | 1 | Frequency select / ramp direction level |
| hold_i | input | 1 | Freeze the ramp |
| tri_en_i | input | 1 | Triangle auto-sweep enable (ramped FSK) |
| update_i | input | 1 | Update event strobe |
| clr_ramp_i | input | 1 | Return word to origin at update events |
| clr_all_i | input | 1 | Hold frequency output and phase at zero |
| word_a_i | input | FW | Low / start tuning word |
| word_b_i | input | FW | High tuning word |
| step_i | input | FW | Step word (two's complement in chirp) |
| rate_i | input | RW | Rate value N: one step per N+1 clocks |
| freq_o | output | FW | Current frequency word |
| phase_o | output | PW | Top bits of the phase accumulator |

## Verification
The bench builds the block with FW = 12, RW = 4 and PW = 6. With these values a full ramp between words takes only a few dozen clocks, and a chirp wraps past 2^12 in either direction within one short run. Every phase value can also be predicted with plain integer arithmetic modulo 4096. This makes it practical to sweep every rate from 1 to 3 against several step sizes. The sweep covers a step that lands exactly on the destination and one that overshoots it, and the bench checks every cycle of each ramp, reversal, hold window and triangle period.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam logic [2:0] MODE_TONE  = 3'b000;
  localparam logic [2:0] MODE_FSK   = 3'b001;
  localparam logic [2:0] MODE_RAMP  = 3'b010;
  localparam logic [2:0] MODE_CHIRP = 3'b011;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } fce_dir_e;
endpackage

// File: rtl/fce_rate_timer.sv
module fce_rate_timer #(
  parameter int RW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    tick   = 1'b0;
    cnt_en = restart | run;
    if (restart) begin
      cnt_d = rate;
    end else if (run) begin
      if (cnt_q == '0) begin
        tick  = 1'b1;
        cnt_d = rate;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fce_freq_step.sv
module fce_freq_step #(
  parameter int FW = 48
) (
  input  logic [FW-1:0] cur,
  input  logic [FW-1:0] delta,
  input  logic [FW-1:0] lo,
  input  logic [FW-1:0] hi,
  input  logic          up,
  input  logic          wrap,
  output logic [FW-1:0] nxt,
  output logic          at_end
);
  logic [FW:0] sum_up;
  logic [FW:0] floor_dn;

  assign sum_up   = {1'b0, cur} + {1'b0, delta};
  assign floor_dn = {1'b0, lo} + {1'b0, delta};

  always_comb begin
    nxt    = cur;
    at_end = 1'b0;
    if (wrap) begin
      nxt = cur + delta;
    end else if (up) begin
      if (sum_up >= {1'b0, hi}) begin
        nxt    = hi;
        at_end = 1'b1;
      end else begin
        nxt = sum_up[FW-1:0];
      end
    end else begin
      if ({1'b0, cur} <= floor_dn) begin
        nxt    = lo;
        at_end = 1'b1;
      end else begin
        nxt = cur - delta;
      end
    end
  end
endmodule

// File: rtl/fce_phase_acc.sv
module fce_phase_acc #(
  parameter int FW = 48,
  parameter int PW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [FW-1:0] freq,
  output logic [PW-1:0] phase
);
  logic [FW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = clear ? '0 : ph_q + freq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else ph_q <= ph_d;
  end

  assign phase = ph_q[FW-1 -: PW];
endmodule

// File: rtl/fsk_chirp_engine.sv
module fsk_chirp_engine
  import fce_pkg::*;
#(
  parameter int FW = 48,
  parameter int RW = 20,
  parameter int PW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_i,
  input  logic          fsk_i,
  input  logic          hold_i,
  input  logic          tri_en_i,
  input  logic          update_i,
  input  logic          clr_ramp_i,
  input  logic          clr_all_i,
  input  logic [FW-1:0] word_a_i,
  input  logic [FW-1:0] word_b_i,
  input  logic [FW-1:0] step_i,
  input  logic [RW-1:0] rate_i,
  output logic [FW-1:0] freq_o,
  output logic [PW-1:0] phase_o
);
  // registered state
  logic [2:0]    mode_q;
  logic          fsk_q, tri_q, active_q, zero_q;
  fce_dir_e      dir_q;
  logic [FW-1:0] cur_q;

  // next state
  logic          active_d;
  fce_dir_e      dir_d;
  logic [FW-1:0] cur_d;
  logic          cur_en;

  // decode
  logic ramp_mode, chirp_mode, swept;
  logic enter_chirp, fsk_edge, tri_start, clr_hit;
  logic load_origin, restart, run;
  logic tick, at_end;
  logic [FW-1:0] step_nxt, sel_word, origin;

  assign ramp_mode   = (mode_i == MODE_RAMP);
  assign chirp_mode  = (mode_i == MODE_CHIRP);
  assign swept       = ramp_mode | chirp_mode;
  assign sel_word    = ((mode_i == MODE_FSK) && fsk_i) ? word_b_i : word_a_i;
  assign enter_chirp = chirp_mode && (mode_q != MODE_CHIRP);
  assign fsk_edge    = ramp_mode && !tri_en_i && (fsk_i != fsk_q);
  assign tri_start   = ramp_mode && tri_en_i && !tri_q;
  assign clr_hit     = swept && update_i && clr_ramp_i;
  assign load_origin = swept && (clr_all_i | enter_chirp | clr_hit | tri_start);
  assign restart     = load_origin | fsk_edge;
  assign run         = swept && !hold_i && !clr_all_i && (chirp_mode || active_q);

  fce_rate_timer #(.RW(RW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (run),
    .rate    (rate_i),
    .tick    (tick)
  );

  fce_freq_step #(.FW(FW)) u_step (
    .cur    (cur_q),
    .delta  (step_i),
    .lo     (word_a_i),
    .hi     (word_b_i),
    .up     (dir_q == DIR_UP),
    .wrap   (chirp_mode),
    .nxt    (step_nxt),
    .at_end (at_end)
  );

  always_comb begin
    dir_d = dir_q;
    if (tri_start)                       dir_d = fsk_i ? DIR_DOWN : DIR_UP;
    else if (fsk_edge)                   dir_d = fsk_i ? DIR_UP : DIR_DOWN;
    else if (tick && at_end && tri_en_i) dir_d = (dir_q == DIR_UP) ? DIR_DOWN : DIR_UP;

    active_d = active_q;
    if (!ramp_mode)                        active_d = 1'b0;
    else if (tri_start || fsk_edge)        active_d = 1'b1;
    else if (tick && at_end && !tri_en_i)  active_d = 1'b0;

    origin = (chirp_mode || dir_d == DIR_UP) ? word_a_i : word_b_i;

    cur_en = 1'b1;
    if (!swept)           cur_d = sel_word;
    else if (load_origin) cur_d = origin;
    else if (tick)        cur_d = step_nxt;
    else begin
      cur_d  = cur_q;
      cur_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_TONE;
      fsk_q    <= 1'b0;
      tri_q    <= 1'b0;
      active_q <= 1'b0;
      zero_q   <= 1'b0;
      dir_q    <= DIR_DOWN;
      cur_q    <= '0;
    end else begin
      mode_q   <= mode_i;
      fsk_q    <= fsk_i;
      tri_q    <= tri_en_i;
      active_q <= active_d;
      zero_q   <= clr_all_i;
      dir_q    <= dir_d;
      if (cur_en) cur_q <= cur_d;
    end
  end

  assign freq_o = zero_q ? '0 : cur_q;

  fce_phase_acc #(.FW(FW), .PW(PW)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clr_all_i),
    .freq  (freq_o),
    .phase (phase_o)
  );
endmodule

// File: rtl/fce_sweep_checker.sv
module fce_sweep_checker #(
  parameter int FW = 48,
  parameter int RW = 20,
  parameter int PW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_i,
  input logic          fsk_i,
  input logic          hold_i,
  input logic          clr_all_i,
  input logic [FW-1:0] word_a_i,
  input logic [FW-1:0] word_b_i,
  input logic [RW-1:0] rate_i,
  input logic [FW-1:0] freq_o,
  input logic [PW-1:0] phase_o,
  input logic          tick,
  input logic          dir_up,
  input logic          ramp_mode
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else seen_q <= 1'b1;
  end

  AST_TONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (mode_i == 3'b000) && !clr_all_i) |=> (freq_o == $past(word_a_i))); // R1

  AST_FSK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (mode_i == 3'b001) && !clr_all_i)
      |=> (freq_o == ($past(fsk_i) ? $past(word_b_i) : $past(word_a_i)))); // R2

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && tick && (rate_i != '0)) |=> !tick); // R3

  AST_UP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && tick && ramp_mode && dir_up) |=> (freq_o <= $past(word_b_i))); // R4

  AST_DOWN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && tick && ramp_mode && !dir_up) |=> (freq_o >= $past(word_a_i))); // R4

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> !tick); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && clr_all_i) |=> ((freq_o == '0) && (phase_o == '0))); // R10
endmodule

bind fsk_chirp_engine fce_sweep_checker #(.FW(FW), .RW(RW), .PW(PW)) u_sweep_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .fsk_i     (fsk_i),
  .hold_i    (hold_i),
  .clr_all_i (clr_all_i),
  .word_a_i  (word_a_i),
  .word_b_i  (word_b_i),
  .rate_i    (rate_i),
  .freq_o    (freq_o),
  .phase_o   (phase_o),
  .tick      (tick),
  .dir_up    (dir_q == fce_pkg::DIR_UP),
  .ramp_mode (ramp_mode)
);

// File: tb/test_fsk_chirp_engine.sv
module test_fsk_chirp_engine;
  localparam int FW = 12;
  localparam int RW = 4;
  localparam int PW = 6;
  localparam int MOD = 1 << FW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    mode_i;
  logic          fsk_i, hold_i, tri_en_i, update_i, clr_ramp_i, clr_all_i;
  logic [FW-1:0] word_a_i, word_b_i, step_i;
  logic [RW-1:0] rate_i;
  logic [FW-1:0] freq_o;
  logic [PW-1:0] phase_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fsk_chirp_engine #(.FW(FW), .RW(RW), .PW(PW)) i_fsk_chirp_engine (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fsk_i(fsk_i), .hold_i(hold_i),
    .tri_en_i(tri_en_i), .update_i(update_i), .clr_ramp_i(clr_ramp_i),
    .clr_all_i(clr_all_i), .word_a_i(word_a_i), .word_b_i(word_b_i),
    .step_i(step_i), .rate_i(rate_i), .freq_o(freq_o), .phase_o(phase_o)
  );

  task automatic tick1();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] up_val(input int lo, input int hi, input int d, input int p);
    int s;
    s = lo + d * p;
    return (s >= hi) ? FW'(hi) : FW'(s);
  endfunction

  function automatic logic [FW-1:0] dn_val(input int hi, input int lo, input int d, input int p);
    int s;
    s = hi - d * p;
    return (s <= lo) ? FW'(lo) : FW'(s);
  endfunction

  function automatic logic [FW-1:0] wrap_val(input int x);
    return FW'(((x % MOD) + MOD) % MOD);
  endfunction

  function automatic int tri6(input int p);
    int m;
    m = p % 6;
    return (m <= 3) ? m : 6 - m;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // ramp from the current end to the other one; word is settled at the start end
  task automatic ramp_leg(input bit go_up, input int lo, input int hi, input int d, input int n);
    int len;
    len = (n + 1) * ((hi - lo) / d + 3);
    fsk_i = go_up;
    tick1();
    chk("R3 restart clock keeps word", freq_o, go_up ? FW'(lo) : FW'(hi));
    for (int i = 1; i <= len; i++) begin
      tick1();
      if (go_up) chk("R3/R4 rising ramp", freq_o, up_val(lo, hi, d, i / (n + 1)));
      else       chk("R3/R4 falling ramp", freq_o, dn_val(hi, lo, d, i / (n + 1)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int ph;
    logic [FW-1:0] fcur;
    int dlist [4];
    dlist[0] = 5; dlist[1] = 7; dlist[2] = 60; dlist[3] = 61;

    rst_n = 1'b0; mode_i = 3'b000; fsk_i = 1'b0; hold_i = 1'b0; tri_en_i = 1'b0;
    update_i = 1'b0; clr_ramp_i = 1'b0; clr_all_i = 1'b0;
    word_a_i = '0; word_b_i = '0; step_i = '0; rate_i = '0;
    repeat (3) tick1();
    chk("R11 reset freq", freq_o, '0);
    chk("R11 reset phase", FW'(phase_o), '0);
    rst_n = 1'b1;

    // R1: tone and reserved modes
    word_a_i = 12'h123; word_b_i = 12'h456; fsk_i = 1'b1;
    for (int m = 0; m < 8; m++) begin
      if (m >= 1 && m <= 3) continue;
      mode_i = 3'(m);
      tick1();
      chk("R1 tone word", freq_o, 12'h123);
    end

    // R2: plain FSK
    mode_i = 3'b001;
    for (int k = 0; k < 8; k++) begin
      word_a_i = FW'(k * 300 + 5);
      word_b_i = FW'(4095 - k * 200);
      fsk_i = k[0];
      tick1();
      chk("R2 fsk select", freq_o, k[0] ? FW'(4095 - k * 200) : FW'(k * 300 + 5));
    end

    // R10 / R11: clear, then phase accumulation with a mid-run change
    mode_i = 3'b000; word_a_i = 12'h0A5; clr_all_i = 1'b1;
    tick1();
    chk("R10 zero freq", freq_o, '0);
    chk("R10 zero phase", FW'(phase_o), '0);
    clr_all_i = 1'b0;
    tick1();
    chk("R11 release freq", freq_o, 12'h0A5);
    chk("R11 release phase", FW'(phase_o), '0);
    ph = 0; fcur = 12'h0A5;
    for (int i = 0; i < 40; i++) begin
      if (i == 20) word_a_i = 12'h31C;
      tick1();
      ph = (ph + int'(fcur)) % MOD;
      fcur = word_a_i;
      chk("R11 phase acc", FW'(phase_o), FW'(ph >> (FW - PW)));
      chk("R11 freq word", freq_o, fcur);
    end

    // R3 / R4: ramped FSK sweep over rates and steps
    word_a_i = FW'(100); word_b_i = FW'(160);
    mode_i = 3'b001; fsk_i = 1'b0;
    tick1();
    mode_i = 3'b010;
    tick1();
    chk("R3 idle before level change", freq_o, FW'(100));
    for (int n = 1; n <= 3; n++) begin
      for (int di = 0; di < 4; di++) begin
        rate_i = RW'(n);
        step_i = FW'(dlist[di]);
        ramp_leg(1'b1, 100, 160, dlist[di], n);
        ramp_leg(1'b0, 100, 160, dlist[di], n);
      end
    end

    // R5: reversal part-way
    rate_i = RW'(2); step_i = FW'(7);
    fsk_i = 1'b1;
    tick1();
    for (int i = 1; i <= 9; i++) begin
      tick1();
      chk("R5 rising before reversal", freq_o, up_val(100, 160, 7, i / 3));
    end
    fsk_i = 1'b0;
    tick1();
    chk("R5 reversal clock", freq_o, FW'(121));
    for (int j = 1; j <= 30; j++) begin
      tick1();
      chk("R5 falling after reversal", freq_o, dn_val(121, 100, 7, j / 3));
    end

    // R8: hold freezes word and timer
    begin
      int eff;
      eff = 0;
      fsk_i = 1'b1;
      tick1();
      for (int i = 1; i <= 50; i++) begin
        hold_i = (i >= 5 && i < 12);
        tick1();
        if (!hold_i) eff++;
        chk("R8 hold ramp", freq_o, up_val(100, 160, 7, eff / 3));
      end
      hold_i = 1'b0;
    end
    ramp_leg(1'b0, 100, 160, 7, 2);

    // R6: triangle from the low end, fsk toggles ignored
    rate_i = RW'(1); step_i = FW'(20);
    tri_en_i = 1'b1;
    tick1();
    chk("R6 triangle start low", freq_o, FW'(100));
    for (int i = 1; i <= 30; i++) begin
      if (i == 7)  fsk_i = 1'b1;
      if (i == 15) fsk_i = 1'b0;
      tick1();
      chk("R6 triangle low start", freq_o, FW'(100 + 20 * tri6(i / 2)));
    end
    tri_en_i = 1'b0;
    tick1();
    fsk_i = 1'b1;
    tick1();
    tri_en_i = 1'b1;
    tick1();
    chk("R6 triangle start high", freq_o, FW'(160));
    for (int i = 1; i <= 30; i++) begin
      tick1();
      chk("R6 triangle high start", freq_o, FW'(160 - 20 * tri6(i / 2)));
    end
    tri_en_i = 1'b0;

    // R7: chirp upward past word B, then downward through zero
    mode_i = 3'b000; fsk_i = 1'b0;
    tick1();
    word_a_i = 12'h800; word_b_i = 12'h810; step_i = FW'(9); rate_i = RW'(2);
    mode_i = 3'b011;
    tick1();
    chk("R7 chirp entry", freq_o, 12'h800);
    for (int i = 1; i <= 60; i++) begin
      tick1();
      chk("R7 chirp up", freq_o, wrap_val(2048 + 9 * (i / 3)));
    end
    mode_i = 3'b000;
    tick1();
    word_a_i = FW'(16); step_i = 12'hFFB;
    mode_i = 3'b011;
    tick1();
    chk("R7 chirp entry down", freq_o, FW'(16));
    for (int i = 1; i <= 45; i++) begin
      tick1();
      chk("R7 chirp down wrap", freq_o, wrap_val(16 - 5 * (i / 3)));
    end

    // R9: clear to origin at update events
    mode_i = 3'b000;
    tick1();
    word_a_i = 12'h800; step_i = FW'(9);
    mode_i = 3'b011;
    tick1();
    for (int i = 1; i <= 10; i++) begin
      tick1();
      chk("R9 chirp before clear", freq_o, wrap_val(2048 + 9 * (i / 3)));
    end
    update_i = 1'b1; clr_ramp_i = 1'b1;
    tick1();
    chk("R9 clear at update", freq_o, 12'h800);
    update_i = 1'b0; clr_ramp_i = 1'b0;
    for (int j = 1; j <= 8; j++) begin
      tick1();
      chk("R9 ramp continues", freq_o, wrap_val(2048 + 9 * (j / 3)));
    end
    update_i = 1'b1;
    tick1();
    chk("R9 update alone ignored", freq_o, wrap_val(2048 + 9 * (9 / 3)));
    update_i = 1'b0; clr_ramp_i = 1'b1;
    for (int r = 0; r < 3; r++) begin
      update_i = 1'b1;
      tick1();
      chk("R9 repeated clear", freq_o, 12'h800);
      update_i = 1'b0;
      for (int j = 1; j <= 4; j++) begin
        tick1();
        chk("R9 between updates", freq_o, wrap_val(2048 + 9 * (j / 3)));
      end
    end
    clr_ramp_i = 1'b0;

    // R10: zero during chirp and resume from origin
    clr_all_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick1();
      chk("R10 chirp zero freq", freq_o, '0);
      chk("R10 chirp zero phase", FW'(phase_o), '0);
    end
    clr_all_i = 1'b0;
    tick1();
    chk("R10 resume origin", freq_o, 12'h800);
    chk("R10 resume phase", FW'(phase_o), '0);
    for (int i = 2; i <= 12; i++) begin
      tick1();
      chk("R10 resume ramp", freq_o, wrap_val(2048 + 9 * (i / 3)));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule